// File: doc/BRIEF.md
# Prefetchable Memory Window Decoder

This block holds the prefetchable memory window of a PCI Express bridge and decides whether a memory transaction address falls inside it, so that the bridge forwards the transaction downstream. The window is described by a 12-bit base field and a 12-bit limit field that cover address bits 31:20. In a 64-bit build it is also described by two 32-bit upper registers that cover address bits 63:32. Together they form a 44-bit base and a 44-bit limit at 1 MB granularity. The bottom of the window sits on a 1 MB boundary. The top is the last byte of the 1 MB block named by the limit.

Configuration software reaches the registers through a simple dword port. The port has a two-bit dword offset, per-byte write enables and a read-data output that always shows the dword at the presented offset. Each 16-bit base or limit half holds its read-only capability nibble below the writable field. The decode side takes an address and a valid flag and returns a combinational hit. The hit is gated by a memory-space-enable input.

A two-state machine tracks whether the window is usable. In state WIN_OPEN the combined limit is at least the combined base. In state WIN_CLOSED the limit is below the base and no address hits. The transition "close" (WIN_OPEN to WIN_CLOSED) is taken when the register values being written put the limit below the base. The transition "reopen" (WIN_CLOSED to WIN_OPEN) is taken when they restore limit >= base. Otherwise the state holds. The machine computes its next state from the next register values, so the state and the registers change on the same edge. After reset all registers are zero, which leaves a 1 MB window at address 0 in state WIN_OPEN.

Top module: `pfw_decoder`

## Requirements
- R1: After reset every writable field is zero. A read of dword offset 0 returns 0x0001_0001 in a build with capability code 1h and 0x0000_0000 in a build with code 0h. Offsets 1 and 2 read zero.
- R2: `dec_hit` is 1 exactly when {base_hi, base_lo} <= dec_addr[63:20] <= {limit_hi, limit_lo} (44-bit unsigned compare, both ends inclusive), with valid and enable asserted.
- R3: Bits 3:0 and 19:16 of dword offset 0 always read as the 4-bit capability code. Writes to those bits are ignored.
- R4: Byte enables at offset 0 work as follows. be[0] writes base_lo[3:0] from wdata[7:4]. be[1] writes base_lo[11:4] from wdata[15:8]. be[2] writes limit_lo[3:0] from wdata[23:20]. be[3] writes limit_lo[11:4] from wdata[31:24]. At offsets 1 and 2, be[i] writes byte i of the register. Fields whose enable is low keep their value.
- R5: The dword offsets are fixed. Offset 0 holds limit_lo in bits 31:20 and base_lo in bits 15:4. Offset 1 holds the 32-bit base_hi. Offset 2 holds the 32-bit limit_hi. Offset 3 reads zero and ignores writes. base_hi and limit_hi read back exactly what was written.
- R6: When the combined limit is below the combined base, the machine is in WIN_CLOSED and no address hits. Writes that raise the limit or lower the base to limit >= base reopen the window.
- R7: The lowest hitting address is base·2^20. The highest is limit·2^20 + 0xFFFFF. The addresses one below and one above these miss.
- R8: The hit is combinational in the same cycle as the address. It is 0 whenever `dec_vld` or `mem_en` is 0.
- R9: A write accepted on a clock edge changes the decode from the cycle after that edge. An address presented in the same cycle as the write is decoded against the old values.
- R10: In a build with capability code 0h, offsets 1 and 2 always read zero and ignore writes. Any address with nonzero bits 63:32 misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, accepted on the rising edge |
| cfg_ofs | input | 2 | Dword offset for write and read |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the dword at `cfg_ofs` (combinational) |
| mem_en | input | 1 | Memory space enable that gates forwarding |
| dec_vld | input | 1 | Decode address valid |
| dec_addr | input | 64 | Transaction byte address |
| dec_hit | output | 1 | Address falls in the window and may be forwarded |

## Verification
On every cycle the assertions check three things. A hit is only raised with valid and enable set and with the address inside the 44-bit window. The WIN_OPEN/WIN_CLOSED state always agrees with the ordering of the stored limit and base. Byte lanes and the upper registers with no enable or no write hold their value, and a 32-bit build never hits above 4 GB. Only the bench scenarios can show that the window edges sit at exactly base·2^20 and limit·2^20+0xFFFFF, that written values read back at the right offsets with the capability nibble in place, and that a write changes the decode one cycle later rather than in the same cycle.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

    localparam int CFG_DW   = 32;
    localparam int BE_W     = CFG_DW / 8;
    localparam int OFS_W    = 2;
    localparam int ADDR_W   = 64;
    localparam int GRAN_W   = 20;
    localparam int CAP_W    = 4;
    localparam int LO_W     = 32 - GRAN_W;
    localparam int HI_W     = ADDR_W - 32;
    localparam int WIN_W    = ADDR_W - GRAN_W;

    localparam logic [OFS_W-1:0] OFS_BASE_LIMIT = 2'd0;
    localparam logic [OFS_W-1:0] OFS_BASE_HI    = 2'd1;
    localparam logic [OFS_W-1:0] OFS_LIMIT_HI   = 2'd2;

    localparam logic [CAP_W-1:0] CAP_32 = 4'h0;
    localparam logic [CAP_W-1:0] CAP_64 = 4'h1;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_e;

endpackage

// File: rtl/pfw_regs.sv
module pfw_regs
    import pfw_pkg::*;
#(
    parameter logic [CAP_W-1:0] CAP_CODE = CAP_64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [OFS_W-1:0]  cfg_ofs,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic [LO_W-1:0]   base_lo_q,
    output logic [LO_W-1:0]   limit_lo_q,
    output logic [HI_W-1:0]   base_hi_q,
    output logic [HI_W-1:0]   limit_hi_q,
    output logic [LO_W-1:0]   base_lo_d,
    output logic [LO_W-1:0]   limit_lo_d,
    output logic [HI_W-1:0]   base_hi_d,
    output logic [HI_W-1:0]   limit_hi_d
);

    // Low nibbles of each half are read-only; those data bits are never stored.
    logic unused_ro_bits;
    assign unused_ro_bits = ^{cfg_wdata[3:0], cfg_wdata[19:16]};

    // Next value of the 12-bit base and limit fields.
    always_comb begin
        base_lo_d  = base_lo_q;
        limit_lo_d = limit_lo_q;
        if (cfg_wr && (cfg_ofs == OFS_BASE_LIMIT)) begin
            if (cfg_be[0]) base_lo_d[3:0]   = cfg_wdata[7:4];
            if (cfg_be[1]) base_lo_d[11:4]  = cfg_wdata[15:8];
            if (cfg_be[2]) limit_lo_d[3:0]  = cfg_wdata[23:20];
            if (cfg_be[3]) limit_lo_d[11:4] = cfg_wdata[31:24];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q  <= '0;
            limit_lo_q <= '0;
        end else begin
            base_lo_q  <= base_lo_d;
            limit_lo_q <= limit_lo_d;
        end
    end

    generate
        if (CAP_CODE == CAP_64) begin : g_upper
            always_comb begin
                base_hi_d  = base_hi_q;
                limit_hi_d = limit_hi_q;
                for (int i = 0; i < BE_W; i++) begin
                    if (cfg_wr && cfg_be[i] && (cfg_ofs == OFS_BASE_HI))
                        base_hi_d[8*i +: 8] = cfg_wdata[8*i +: 8];
                    if (cfg_wr && cfg_be[i] && (cfg_ofs == OFS_LIMIT_HI))
                        limit_hi_d[8*i +: 8] = cfg_wdata[8*i +: 8];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_hi_q  <= '0;
                    limit_hi_q <= '0;
                end else begin
                    base_hi_q  <= base_hi_d;
                    limit_hi_q <= limit_hi_d;
                end
            end

            // R5: upper registers move only on a write to their own offset
            assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_wr && (cfg_ofs == OFS_BASE_HI)) |=> $stable(base_hi_q));
            assert_upper_lim_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_wr && (cfg_ofs == OFS_LIMIT_HI)) |=> $stable(limit_hi_q));
        end else begin : g_no_upper
            assign base_hi_d  = '0;
            assign limit_hi_d = '0;
            assign base_hi_q  = '0;
            assign limit_hi_q = '0;
        end
    endgenerate

    // Read mux: the capability code sits below each 12-bit field.
    always_comb begin
        unique case (cfg_ofs)
            OFS_BASE_LIMIT: cfg_rdata = {limit_lo_q, CAP_CODE, base_lo_q, CAP_CODE};
            OFS_BASE_HI:    cfg_rdata = base_hi_q;
            OFS_LIMIT_HI:   cfg_rdata = limit_hi_q;
            default:        cfg_rdata = '0;
        endcase
    end

    // R4: a disabled byte lane keeps its field
    assert_be_limit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_ofs == OFS_BASE_LIMIT) && !cfg_be[3]) |=> $stable(limit_lo_q[11:4]));
    assert_be_base_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_ofs == OFS_BASE_LIMIT) && !cfg_be[0]) |=> $stable(base_lo_q[3:0]));
    // R9: without an accepted write the low fields do not move
    assert_no_write_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(base_lo_q) && $stable(limit_lo_q)));

endmodule

// File: rtl/pfw_window_fsm.sv
module pfw_window_fsm
    import pfw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] base_d,
    input  logic [WIN_W-1:0] limit_d,
    input  logic [WIN_W-1:0] base_q,
    input  logic [WIN_W-1:0] limit_q,
    output logic             win_open
);

    win_state_e state_q;
    win_state_e state_d;

    // Next state: look at the register values that the same edge will load.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_OPEN: begin
                if (limit_d < base_d) state_d = WIN_CLOSED;   // close
            end
            WIN_CLOSED: begin
                if (limit_d >= base_d) state_d = WIN_OPEN;    // reopen
            end
            default: state_d = WIN_OPEN;
        endcase
    end

    // Registers reset to zero, so limit == base and the window starts open.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        win_open = (state_q == WIN_OPEN);
    end

    // R6: the state always matches the ordering of the stored registers
    assert_state_tracks_regs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_OPEN) == (limit_q >= base_q));

endmodule

// File: rtl/pfw_match.sv
module pfw_match
    import pfw_pkg::*;
#(
    parameter logic [CAP_W-1:0] CAP_CODE = CAP_64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_vld,
    input  logic              mem_en,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic [WIN_W-1:0]  base_q,
    input  logic [WIN_W-1:0]  limit_q,
    input  logic              win_open,
    output logic              dec_hit
);

    logic [ADDR_W-1:0] lo_bound;
    logic [ADDR_W-1:0] hi_bound;
    logic              above_lo;
    logic              below_hi;

    // Byte-level bounds: base aligned down, limit filled to the end of its 1 MB block.
    always_comb begin
        lo_bound = {base_q,  {GRAN_W{1'b0}}};
        hi_bound = {limit_q, {GRAN_W{1'b1}}};
        above_lo = (dec_addr >= lo_bound);
        below_hi = (dec_addr <= hi_bound);
        dec_hit  = dec_vld && mem_en && win_open && above_lo && below_hi;
    end

    // R8: no forwarding without valid and enable
    assert_hit_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> (dec_vld && mem_en));
    // R2: a hit lies inside the 44-bit window
    assert_hit_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> ((dec_addr[ADDR_W-1:GRAN_W] >= base_q) && (dec_addr[ADDR_W-1:GRAN_W] <= limit_q)));
    // R6: a closed window forwards nothing
    assert_closed_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |-> !dec_hit);

    generate
        if (CAP_CODE == CAP_32) begin : g_chk32
            // R10: nothing above 4 GB in a 32-bit build
            assert_upper_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (|dec_addr[ADDR_W-1:32]) |-> !dec_hit);
        end
    endgenerate

endmodule

// File: rtl/pfw_decoder.sv
module pfw_decoder
    import pfw_pkg::*;
#(
    parameter logic [CAP_W-1:0] CAP_CODE = CAP_64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [OFS_W-1:0]  cfg_ofs,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              mem_en,
    input  logic              dec_vld,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic              dec_hit
);

    logic [LO_W-1:0] base_lo_q;
    logic [LO_W-1:0] limit_lo_q;
    logic [HI_W-1:0] base_hi_q;
    logic [HI_W-1:0] limit_hi_q;
    logic [LO_W-1:0] base_lo_d;
    logic [LO_W-1:0] limit_lo_d;
    logic [HI_W-1:0] base_hi_d;
    logic [HI_W-1:0] limit_hi_d;
    logic            win_open;

    logic [WIN_W-1:0] base_q;
    logic [WIN_W-1:0] limit_q;
    logic [WIN_W-1:0] base_d;
    logic [WIN_W-1:0] limit_d;

    assign base_q  = {base_hi_q,  base_lo_q};
    assign limit_q = {limit_hi_q, limit_lo_q};
    assign base_d  = {base_hi_d,  base_lo_d};
    assign limit_d = {limit_hi_d, limit_lo_d};

    pfw_regs #(.CAP_CODE(CAP_CODE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_ofs    (cfg_ofs),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .base_lo_q  (base_lo_q),
        .limit_lo_q (limit_lo_q),
        .base_hi_q  (base_hi_q),
        .limit_hi_q (limit_hi_q),
        .base_lo_d  (base_lo_d),
        .limit_lo_d (limit_lo_d),
        .base_hi_d  (base_hi_d),
        .limit_hi_d (limit_hi_d)
    );

    pfw_window_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_d   (base_d),
        .limit_d  (limit_d),
        .base_q   (base_q),
        .limit_q  (limit_q),
        .win_open (win_open)
    );

    pfw_match #(.CAP_CODE(CAP_CODE)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_vld  (dec_vld),
        .mem_en   (mem_en),
        .dec_addr (dec_addr),
        .base_q   (base_q),
        .limit_q  (limit_q),
        .win_open (win_open),
        .dec_hit  (dec_hit)
    );

endmodule

// File: tb/test_pfw_decoder.sv
`timescale 1ns/1ps
module test_pfw_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_ofs = 2'd0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        mem_en = 1'b0;
    logic        dec_vld = 1'b0;
    logic [63:0] dec_addr = 64'h0;
    logic [31:0] rdata64, rdata32;
    logic        hit64, hit32;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural model state
    logic [11:0] m_blo, m_llo;
    logic [31:0] m_bhi, m_lhi;

    always #5 clk = ~clk;

    pfw_decoder i_pfw_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata64), .mem_en(mem_en), .dec_vld(dec_vld),
        .dec_addr(dec_addr), .dec_hit(hit64)
    );

    pfw_decoder #(.CAP_CODE(4'h0)) i_pfw_decoder_w32 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata32), .mem_en(mem_en), .dec_vld(dec_vld),
        .dec_addr(dec_addr), .dec_hit(hit32)
    );

    function automatic logic [31:0] exp_rdata(input bit wide);
        logic [3:0] cap;
        cap = wide ? 4'h1 : 4'h0;
        case (cfg_ofs)
            2'd0:    return {m_llo, cap, m_blo, cap};
            2'd1:    return wide ? m_bhi : 32'h0;
            2'd2:    return wide ? m_lhi : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_hit(input bit wide);
        logic [43:0] b, l, a;
        b = {(wide ? m_bhi : 32'h0), m_blo};
        l = {(wide ? m_lhi : 32'h0), m_llo};
        a = dec_addr[63:20];
        return dec_vld && mem_en && (a >= b) && (a <= l);
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    // Inputs are set by the caller after a falling edge; check, then take one clock.
    task automatic step(input string tag);
        #1;
        check(tag, "rdata64", {32'h0, rdata64}, {32'h0, exp_rdata(1'b1)});
        check(tag, "rdata32", {32'h0, rdata32}, {32'h0, exp_rdata(1'b0)});
        check(tag, "hit64", {63'h0, hit64}, {63'h0, exp_hit(1'b1)});
        check(tag, "hit32", {63'h0, hit32}, {63'h0, exp_hit(1'b0)});
        @(posedge clk);
        if (rst_n && cfg_wr) begin
            case (cfg_ofs)
                2'd0: begin
                    if (cfg_be[0]) m_blo[3:0]  = cfg_wdata[7:4];
                    if (cfg_be[1]) m_blo[11:4] = cfg_wdata[15:8];
                    if (cfg_be[2]) m_llo[3:0]  = cfg_wdata[23:20];
                    if (cfg_be[3]) m_llo[11:4] = cfg_wdata[31:24];
                end
                2'd1: for (int i = 0; i < 4; i++) if (cfg_be[i]) m_bhi[8*i +: 8] = cfg_wdata[8*i +: 8];
                2'd2: for (int i = 0; i < 4; i++) if (cfg_be[i]) m_lhi[8*i +: 8] = cfg_wdata[8*i +: 8];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] ofs, input logic [3:0] be, input logic [31:0] d, input string tag);
        cfg_wr = 1'b1; cfg_ofs = ofs; cfg_be = be; cfg_wdata = d;
        step(tag);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic rd(input logic [1:0] ofs, input string tag);
        cfg_ofs = ofs;
        step(tag);
    endtask

    task automatic probe(input logic [63:0] a, input string tag);
        dec_vld = 1'b1; dec_addr = a;
        step(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_blo = '0; m_llo = '0; m_bhi = '0; m_lhi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values at every offset
        rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R1");
        mem_en = 1'b1;
        probe(64'h0000_0000_000F_FFFF, "R1");
        probe(64'h0000_0000_0010_0000, "R1");

        // R5 upper registers, R3 read-only nibbles ignored on write
        wr(2'd1, 4'hF, 32'h0000_0001, "R5");
        wr(2'd2, 4'hF, 32'h0000_0001, "R5");
        wr(2'd0, 4'hF, 32'h005F_003A, "R3");
        rd(2'd0, "R3"); rd(2'd1, "R5"); rd(2'd2, "R5"); rd(2'd3, "R5");
        wr(2'd3, 4'hF, 32'hFFFF_FFFF, "R5");
        rd(2'd3, "R5"); rd(2'd0, "R5");

        // R2 / R7 window edges: 0x1_0030_0000 .. 0x1_005F_FFFF
        probe(64'h0000_0001_0030_0000, "R7");
        probe(64'h0000_0001_002F_FFFF, "R7");
        probe(64'h0000_0001_005F_FFFF, "R7");
        probe(64'h0000_0001_0060_0000, "R7");
        probe(64'h0000_0001_0045_1234, "R2");
        probe(64'h0000_0000_0045_1234, "R10");
        probe(64'h0000_0002_0045_1234, "R2");

        // R8 qualification
        dec_vld = 1'b0; dec_addr = 64'h0000_0001_0040_0000; step("R8");
        dec_vld = 1'b1; mem_en = 1'b0; step("R8");
        mem_en = 1'b1; step("R8");

        // R4 partial byte enables, which also close the window (R6)
        wr(2'd0, 4'b0011, 32'hFFF0_0070, "R4");
        rd(2'd0, "R4");
        probe(64'h0000_0001_0050_0000, "R6");
        probe(64'h0000_0001_0000_7000, "R6");
        wr(2'd1, 4'b0100, 32'h00AB_0000, "R4");
        rd(2'd1, "R4");

        // R9 write and probe in the same cycle: old values decode first
        wr(2'd1, 4'hF, 32'h0000_0001, "R9");
        dec_addr = 64'h0000_0001_0070_0000; dec_vld = 1'b1;
        wr(2'd0, 4'b1100, 32'h0080_0000, "R9");
        step("R9");
        dec_addr = 64'h0000_0001_0080_0000; step("R9");
        dec_addr = 64'h0000_0001_0080_0001; step("R9");
        dec_addr = 64'h0000_0001_008F_FFFF; step("R9");

        // R6 upper-only inversion closes, then reopen
        wr(2'd1, 4'hF, 32'h0000_0002, "R6");
        probe(64'h0000_0001_0010_0000, "R6");
        probe(64'h0000_0002_0010_0000, "R6");
        wr(2'd2, 4'hF, 32'h0000_0003, "R6");
        probe(64'h0000_0002_0010_0000, "R6");
        probe(64'h0000_0003_008F_FFFF, "R6");
        probe(64'h0000_0003_0090_0000, "R6");

        // R10 32-bit build: same low window, nothing above 4 GB
        wr(2'd1, 4'hF, 32'h0, "R10");
        probe(64'h0000_0000_0009_0000, "R10");
        probe(64'h0000_0000_008F_FFFF, "R10");
        probe(64'h8000_0000_0010_0000, "R10");

        // R2 mixed random traffic near the programmed window
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom;
            if (r[2:0] == 3'd0) begin
                wr(2'(r[4:3]), 4'(r[8:5]), {r[31:20], 4'h0, r[19:9], 5'h0}, "R2");
            end else begin
                logic [63:0] a;
                a = {30'h0, r[1:0], r[31:4], r[3:0]};
                dec_vld = (r[8:5] != 4'h0);
                mem_en  = (r[12:9] != 4'h0);
                dec_addr = a;
                cfg_ofs = 2'(r[14:13]);
                step("R2");
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule